// File: doc/BRIEF.md
# Packed Audio Word Sample Unpacker

This block sits between an audio sample FIFO and a two-channel serial audio transmitter. Each 64-bit FIFO word carries several PCM samples packed side by side. The block accepts one word at a time over a valid/ready input and sends the samples out one at a time over a valid/ready output. Each sample leaves with its slot index and a left/right channel tag.

A format code sets the container layout: eight 8-bit slots, four 16-bit slots or two 32-bit slots, with each sample right-justified in its slot. An 8-bit slot mask says which slots carry audio. Typical values are 0x01 for mono and 0x03 for stereo. A 5-bit MSB-position field gives the sample width minus one. The block shifts each sample so that its MSB lands at bit 23 of a 24-bit audio field. The format code, mask and MSB position are captured when a word is accepted, so they apply to that word as a whole.

A format code outside the three supported layouts still consumes the word, but no sample is emitted and a sticky error flag is raised.

Top module: `pcm_word_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `fmt_err` is 0.
- R2: With `cfg_fmt` = 0, slot k (k = 0..7) holds `in_data[8k+7:8k]`.
- R3: With `cfg_fmt` = 2, slot k (k = 0..3) holds `in_data[16k+15:16k]`.
- R4: With `cfg_fmt` = 4, slot k (k = 0..1) holds `in_data[32k+31:32k]`.
- R5: Samples leave in ascending slot order. Slots whose bit in `cfg_mask` is 0 are skipped, and mask bits at or above the slot count of the format are ignored.
- R6: For an MSB position p, output bit 23 carries slot bit p. When p < 23 the lower output bits are zero and slot bits above p are dropped. When p > 23 the slot bits below p-23 are dropped.
- R7: `out_slot` gives the slot index of the current sample. `out_chan` is 0 for even slots (left) and 1 for odd slots (right).
- R8: `in_ready` stays low while any enabled slot of the held word is still to be sent. It rises at the first clock edge after the handshake of the last enabled slot. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `out_valid` rises at that same edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample`, `out_slot` and `out_chan` hold their values.
- R10: A word accepted with `cfg_fmt` not in {0, 2, 4} produces no sample, leaves `in_ready` high and sets `fmt_err`. `fmt_err` then stays 1 until reset.
- R11: A word with no enabled slot, after masking by the slot count, is consumed and produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Container layout code (0: 8x8, 2: 4x16, 4: 2x32) |
| cfg_mask | input | 8 | Slot enable mask, bit k enables slot k |
| cfg_msb_pos | input | 5 | Sample MSB position within its slot (width minus one) |
| in_valid | input | 1 | Packed word available |
| in_data | input | 64 | Packed word |
| in_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Transmitter takes the sample |
| out_sample | output | 24 | MSB-aligned sample |
| out_slot | output | 3 | Slot index of the sample |
| out_chan | output | 1 | Channel tag, 0 left, 1 right |
| fmt_err | output | 1 | Sticky unsupported-format flag |

## Verification
An accepted word shows its first enabled sample on the outputs right after the accepting edge. Each following sample appears one edge after the previous handshake. `in_ready` returns one edge after the last handshake, and `fmt_err` rises one edge after a bad word is taken. The bench drives inputs and samples outputs on falling edges, so every check sits half a cycle after the edge that made its result. Under back-pressure the bench holds `out_ready` low for several cycles and confirms that the outputs do not change and that `in_ready` stays low.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;

  localparam int SLOT_MAX = 8;

  localparam logic [2:0] FMT_BYTES  = 3'd0;
  localparam logic [2:0] FMT_HALVES = 3'd2;
  localparam logic [2:0] FMT_WORDS  = 3'd4;

  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_BAD = 2'd3
  } lane_e;

  function automatic lane_e lane_of(input logic [2:0] code);
    case (code)
      FMT_BYTES:  return LANE_8;
      FMT_HALVES: return LANE_16;
      FMT_WORDS:  return LANE_32;
      default:    return LANE_BAD;
    endcase
  endfunction

  function automatic logic [SLOT_MAX-1:0] lane_slots(input lane_e l);
    case (l)
      LANE_8:  return 8'hFF;
      LANE_16: return 8'h0F;
      LANE_32: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pcm_slot_pick.sv
module pcm_slot_pick
  import pcm_unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 3,
  localparam int RAW_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] word,
  input  lane_e             lane,
  input  logic [IDX_W-1:0]  idx,
  output logic [RAW_W-1:0]  raw
);

  logic [RAW_W-1:0] cand [3];

  // one candidate per container width
  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam int LW = 8 << g;
    localparam int NS = WORD_W / LW;
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;
    logic [SW-1:0] sel;
    assign sel     = idx[SW-1:0];
    assign cand[g] = RAW_W'(word[int'(sel)*LW +: LW]);
  end

  always_comb begin
    case (lane)
      LANE_8:  raw = cand[0];
      LANE_16: raw = cand[1];
      LANE_32: raw = cand[2];
      default: raw = '0;
    endcase
  end

endmodule

// File: rtl/pcm_msb_align.sv
module pcm_msb_align #(
  parameter int RAW_W = 32,
  parameter int OUT_W = 24,
  parameter int POS_W = 5
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [POS_W-1:0] pos,
  output logic [OUT_W-1:0] aligned
);

  localparam int WIDE_W = RAW_W + OUT_W;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] shifted;
  logic [POS_W:0]    shamt;

  // slot bit pos sits at wide bit pos+OUT_W; shift it down to OUT_W-1
  always_comb begin
    wide    = {raw, {OUT_W{1'b0}}};
    shamt   = {1'b0, pos} + 1'b1;
    shifted = wide >> shamt;
    aligned = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/pcm_slot_sched.sv
module pcm_slot_sched #(
  parameter int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic [N-1:0]     pend_after
);

  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    any        = |pend;
    pend_after = pend & ~(N'(1) << idx);
  end

endmodule

// File: rtl/pcm_word_unpacker.sv
module pcm_word_unpacker
  import pcm_unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 24,
  parameter int POS_W  = 5,
  parameter int MASK_W = SLOT_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_fmt,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [POS_W-1:0]  cfg_msb_pos,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_sample,
  output logic [$clog2(MASK_W)-1:0] out_slot,
  output logic              out_chan,
  output logic              fmt_err
);

  localparam int RAW_W = WORD_W / 2;
  localparam int IDX_W = $clog2(MASK_W);

  // held word state
  logic [WORD_W-1:0] word_q, word_d;
  lane_e             lane_q, lane_d;
  logic [POS_W-1:0]  pos_q,  pos_d;
  logic [MASK_W-1:0] pend_q, pend_d;
  logic              err_q,  err_d;
  logic              load_en;

  logic [IDX_W-1:0]  cur_idx;
  logic              any_pend;
  logic [MASK_W-1:0] pend_after;
  logic [RAW_W-1:0]  cur_raw;
  lane_e             lane_in;
  logic              accept, fire;

  pcm_slot_sched #(.N(MASK_W)) sched_i (
    .pend       (pend_q),
    .idx        (cur_idx),
    .any        (any_pend),
    .pend_after (pend_after)
  );

  pcm_slot_pick #(.WORD_W(WORD_W), .IDX_W(IDX_W)) pick_i (
    .word (word_q),
    .lane (lane_q),
    .idx  (cur_idx),
    .raw  (cur_raw)
  );

  pcm_msb_align #(.RAW_W(RAW_W), .OUT_W(OUT_W), .POS_W(POS_W)) align_i (
    .raw     (cur_raw),
    .pos     (pos_q),
    .aligned (out_sample)
  );

  assign in_ready  = ~any_pend;
  assign out_valid = any_pend;
  assign out_slot  = cur_idx;
  assign out_chan  = cur_idx[0];
  assign fmt_err   = err_q;
  assign accept    = in_valid & in_ready;
  assign fire      = out_valid & out_ready;
  assign lane_in   = lane_of(cfg_fmt);
  assign load_en   = accept;

  // next state
  always_comb begin
    word_d = in_data;
    lane_d = lane_in;
    pos_d  = cfg_msb_pos;
    pend_d = pend_q;
    err_d  = err_q;
    if (accept) begin
      if (lane_in == LANE_BAD) begin
        err_d  = 1'b1;
        pend_d = '0;
      end else begin
        pend_d = cfg_mask & lane_slots(lane_in);
      end
    end else if (fire) begin
      pend_d = pend_after;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lane_q <= LANE_8;
      pos_q  <= '0;
    end else if (load_en) begin
      word_q <= word_d;
      lane_q <= lane_d;
      pos_q  <= pos_d;
    end
  end

endmodule

// File: rtl/pcm_word_unpacker_chk.sv
module pcm_word_unpacker_chk #(
  parameter int OUT_W  = 24,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_fmt,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_sample,
  input logic [IDX_W-1:0] out_slot,
  input logic             out_chan,
  input logic             fmt_err
);

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sample) && $stable(out_slot) && $stable(out_chan)));

  // R5
  slot_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || (out_slot > $past(out_slot))));

  // R10
  bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_fmt != 3'd0 && cfg_fmt != 3'd2 && cfg_fmt != 3'd4)
      |=> (fmt_err && !out_valid));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

endmodule

bind pcm_word_unpacker pcm_word_unpacker_chk #(
  .OUT_W (OUT_W),
  .IDX_W ($clog2(MASK_W))
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_fmt    (cfg_fmt),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .out_slot   (out_slot),
  .out_chan   (out_chan),
  .fmt_err    (fmt_err)
);

// File: tb/pcm_word_unpacker_tb_top.sv
`timescale 1ns/1ps
module pcm_word_unpacker_tb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_fmt;
  logic [7:0]  cfg_mask;
  logic [4:0]  cfg_msb_pos;
  logic        in_valid;
  logic [63:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_sample;
  logic [2:0]  out_slot;
  logic        out_chan;
  logic        fmt_err;

  int n_checks = 0;
  int n_fail   = 0;

  logic [23:0] got_s    [8];
  logic [2:0]  got_slot [8];
  logic        got_chan [8];

  pcm_word_unpacker dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fmt     (cfg_fmt),
    .cfg_mask    (cfg_mask),
    .cfg_msb_pos (cfg_msb_pos),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_sample  (out_sample),
    .out_slot    (out_slot),
    .out_chan    (out_chan),
    .fmt_err     (fmt_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) act=hung exp=done");
    report();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // independent model of the MSB placement
  function automatic logic [23:0] model_align(input logic [31:0] raw, input int p);
    logic [31:0] m;
    if (p <= 23) begin
      m = raw & ((32'h1 << (p + 1)) - 32'h1);
      return 24'(m << (23 - p));
    end
    return 24'(raw >> (p - 23));
  endfunction

  task automatic push(input logic [63:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int n);
    out_ready = 1'b1;
    for (int k = 0; k < n; k++) begin
      while (!out_valid) @(negedge clk);
      got_s[k]    = out_sample;
      got_slot[k] = out_slot;
      got_chan[k] = out_chan;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    // R1
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    check(fmt_err == 1'b0, "R1 fmt_err", 64'(fmt_err), 64'd0);
  endtask

  task automatic t_bytes();
    logic [63:0] w;
    w = 64'hF0E1_D2C3_B4A5_9687;
    cfg_fmt = 3'd0; cfg_mask = 8'hFF; cfg_msb_pos = 5'd7;
    push(w);
    collect(8);
    for (int k = 0; k < 8; k++) begin
      // R2 R6
      check(got_s[k] == model_align(32'(w[8*k +: 8]), 7), "R2 byte sample",
            64'(got_s[k]), 64'(model_align(32'(w[8*k +: 8]), 7)));
      // R5 R7
      check(got_slot[k] == 3'(k), "R5 slot order", 64'(got_slot[k]), 64'(k));
      check(got_chan[k] == k[0], "R7 channel tag", 64'(got_chan[k]), 64'(k[0]));
    end
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 idle after word",
          64'({out_valid, in_ready}), 64'b01);
  endtask

  task automatic t_halves_masked();
    logic [63:0] w;
    w = 64'h1234_0ABC_5678_9DEF;
    cfg_fmt = 3'd2; cfg_mask = 8'h0A; cfg_msb_pos = 5'd15;
    push(w);
    collect(2);
    // R3 R5
    check(got_slot[0] == 3'd1 && got_slot[1] == 3'd3, "R5 masked skip",
          64'({got_slot[0], got_slot[1]}), 64'({3'd1, 3'd3}));
    check(got_s[0] == 24'h567800, "R3 half slot1", 64'(got_s[0]), 64'h567800);
    check(got_s[1] == 24'h123400, "R3 half slot3", 64'(got_s[1]), 64'h123400);
    check(out_valid == 1'b0, "R5 no extra sample", 64'(out_valid), 64'd0);
    // R6: 12-bit samples, bits above p dropped
    cfg_msb_pos = 5'd11; cfg_mask = 8'h04;
    push(w);
    collect(1);
    check(got_s[0] == 24'hABC000, "R6 msb 11", 64'(got_s[0]), 64'hABC000);
    // R11 and R5: only mask bits beyond four slots
    cfg_mask = 8'hF0;
    push(w);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 empty word consumed",
          64'({out_valid, in_ready}), 64'b01);
  endtask

  task automatic t_words();
    logic [63:0] w;
    w = 64'hFFAB_CDEF_0012_3456;
    cfg_fmt = 3'd4; cfg_mask = 8'h03; cfg_msb_pos = 5'd23;
    push(w);
    collect(2);
    // R4 R6
    check(got_s[0] == 24'h123456, "R4 word slot0", 64'(got_s[0]), 64'h123456);
    check(got_s[1] == 24'hABCDEF, "R4 word slot1", 64'(got_s[1]), 64'hABCDEF);
    check(got_chan[0] == 1'b0 && got_chan[1] == 1'b1, "R7 stereo tags",
          64'({got_chan[0], got_chan[1]}), 64'b01);
    // R6 msb above 23 drops low bits
    cfg_msb_pos = 5'd31; cfg_mask = 8'h02;
    push(w);
    collect(1);
    check(got_s[0] == model_align(32'hFFABCDEF, 31), "R6 msb 31",
          64'(got_s[0]), 64'(model_align(32'hFFABCDEF, 31)));
  endtask

  task automatic t_backpressure();
    logic [23:0] s0;
    cfg_fmt = 3'd0; cfg_mask = 8'h03; cfg_msb_pos = 5'd7;
    out_ready = 1'b0;
    push(64'h0000_0000_0000_5AA5);
    s0 = out_sample;
    check(out_valid == 1'b1, "R8 out_valid after accept", 64'(out_valid), 64'd1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      // R9
      check(out_valid && out_sample == s0 && out_slot == 3'd0, "R9 hold",
            64'(out_sample), 64'(s0));
      check(in_ready == 1'b0, "R8 ready low while pending", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_slot == 3'd1 && out_sample == 24'h5A0000, "R9 next after release",
          64'(out_sample), 64'h5A0000);
    check(in_ready == 1'b0, "R8 ready low before last", 64'(in_ready), 64'd0);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8 ready one edge after last",
          64'({in_ready, out_valid}), 64'b10);
  endtask

  task automatic t_badfmt();
    cfg_fmt = 3'd1; cfg_mask = 8'hFF; cfg_msb_pos = 5'd7;
    push(64'hDEAD_BEEF_CAFE_F00D);
    // R10
    check(fmt_err == 1'b1, "R10 err set", 64'(fmt_err), 64'd1);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 no output",
          64'({out_valid, in_ready}), 64'b01);
    cfg_fmt = 3'd4; cfg_mask = 8'h01; cfg_msb_pos = 5'd23;
    push(64'h0000_0000_0011_2233);
    collect(1);
    check(got_s[0] == 24'h112233, "R10 good word after error", 64'(got_s[0]), 64'h112233);
    check(fmt_err == 1'b1, "R10 err sticky", 64'(fmt_err), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_fmt = 3'd0; cfg_mask = 8'h00; cfg_msb_pos = 5'd0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_halves_masked();
    t_words();
    t_backpressure();
    t_badfmt();
    report();
    $finish;
  end

endmodule